// File: doc/BRIEF.md
# Write Precompensation Delay Selector

This block moves each write-data flux pulse a few fast-clock steps earlier or later so that the pulses land where they should on the medium. Neighbouring transitions on the medium push each other apart. The block therefore looks at the spacing to the previous pulse and to the next pulse. When the following neighbour is closer, the pulse is written late. When the preceding neighbour is closer, it is written early. When both neighbours are equally close, or neither is within reach, the pulse is left alone. Every pulse passes through a fixed nominal delay, so an early shift only shortens that delay and the output stays causal.

A 3-bit code sets the size of the shift in units of one fast-clock period, nominally 41.67 ns at 24 MHz. One code value turns compensation off. Another picks a default that depends on the data rate. Compensation applies only when the current track number is at or above a programmable starting track. Below that track every pulse leaves with just the nominal delay. The stream is expected to come from an encoder that never places two pulses closer than 2*MAX_DLY+2 clocks apart, where MAX_DLY is six units.

Top module: `write_precomp`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, wd_out is 0. Pulses presented on wd_in during reset never reach the output.
- R2: A pulse whose two neighbours sit at equal distance, or where neither is within WIN clocks, appears on wd_out exactly WIN+1+MAX_DLY clocks after the edge that samples it. MAX_DLY = 6*CLK_PER_UNIT.
- R3: A pulse whose following neighbour is strictly closer than its preceding neighbour leaves S clocks later than in R2, where S is the selected shift.
- R4: A pulse whose preceding neighbour is strictly closer than its following neighbour leaves S clocks earlier than in R2.
- R5: Code 3'b111 gives S = 0 for any rate and track.
- R6: Codes 3'b001 to 3'b110 give S = code*CLK_PER_UNIT clocks.
- R7: Code 3'b000 gives S = 3 units when rate_sel is 2'b00 (500 kbps), 2'b01 (300 kbps) or 2'b10 (250 kbps), and 1 unit when rate_sel is 2'b11 (1 Mbps).
- R8: When track_cur < track_start, S = 0. When track_cur is equal to or greater than track_start, S follows R5 to R7.
- R9: Each input pulse yields exactly one output pulse that is one clock wide. No other output pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period is one shift unit when CLK_PER_UNIT = 1 |
| rst_n | input | 1 | Synchronous active-low reset |
| wd_in | input | 1 | Write data pulse stream, one clock per pulse |
| pc_code | input | 3 | Shift size code: 000 rate default, 001..110 units, 111 off |
| rate_sel | input | 2 | Data rate: 00 500k, 01 300k, 10 250k, 11 1M |
| track_cur | input | TRACK_W | Track the head is on |
| track_start | input | TRACK_W | First track that receives compensation |
| wd_out | output | 1 | Precompensated write data pulse stream |

## Verification
A pulse sampled at edge e must appear after edge e+WIN+1+MAX_DLY±S. The first register stage accounts for the 1. WIN edges carry the pulse to the centre tap. The remaining MAX_DLY±S edges run through the output line. The bench places every expected pulse in a per-cycle table using that count. It takes the neighbour distances, the shift and the track gate from its own model of the requirements, and compares wd_out against the table at every falling edge, so a pulse that is one cycle early or late shows up as two mismatches. The settings are held steady for each burst and change only during idle gaps longer than the window, so every pulse is judged against a single setting.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the write precompensation selector.
// Assumes the code and rate encodings listed in the brief.
package wpc_pkg;
    typedef enum logic [1:0] {
        SHIFT_NONE  = 2'b00,
        SHIFT_EARLY = 2'b01,
        SHIFT_LATE  = 2'b10
    } shift_dir_t;

    localparam int          UNITS_MAX   = 6;
    localparam logic [2:0]  PC_DEFAULT  = 3'b000;
    localparam logic [2:0]  PC_OFF      = 3'b111;
    localparam logic [1:0]  RATE_1M     = 2'b11;
    localparam int          DEF_UNITS_SLOW = 3;
    localparam int          DEF_UNITS_FAST = 1;
endpackage

// File: rtl/wpc_step_decode.sv
`timescale 1ns/1ps
// Turns the shift code, rate and track gate into a shift size in clocks.
// Purely combinational; the caller holds the inputs steady per burst.
module wpc_step_decode
    import wpc_pkg::*;
#(
    parameter int TRACK_W      = 8,
    parameter int CLK_PER_UNIT = 1,
    parameter int STEP_W       = 3
) (
    input  logic [2:0]         pc_code,
    input  logic [1:0]         rate_sel,
    input  logic [TRACK_W-1:0] track_cur,
    input  logic [TRACK_W-1:0] track_start,
    output logic [STEP_W-1:0]  shift_steps
);
    int units;

    // Map the code to units, then gate with the starting-track compare.
    always_comb begin
        case (pc_code)
            PC_OFF:     units = 0;
            PC_DEFAULT: units = (rate_sel == RATE_1M) ? DEF_UNITS_FAST : DEF_UNITS_SLOW;
            default:    units = int'(pc_code);
        endcase
        if (track_cur < track_start)
            units = 0;
        shift_steps = STEP_W'(units * CLK_PER_UNIT);
    end
endmodule

// File: rtl/wpc_pattern.sv
`timescale 1ns/1ps
// Holds the recent pulse history in a tapped line and classifies the pulse
// at the centre tap by comparing distances to its nearest neighbours.
// Assumes at most one neighbour per side inside the window.
module wpc_pattern
    import wpc_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd_in,
    output logic       center_hit,
    output shift_dir_t dir
);
    localparam int LEN    = 2 * WIN + 1;
    localparam int DIST_W = $clog2(WIN + 2);

    logic [LEN-1:0]    tap;
    logic [DIST_W-1:0] d_next;
    logic [DIST_W-1:0] d_prev;

    // Shift new samples in at index 0; older samples move to higher indices.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tap <= '0;
        else
            tap <= {tap[LEN-2:0], wd_in};
    end

    assign center_hit = tap[WIN];

    // Find the nearest later and earlier pulse; WIN+1 means none in reach.
    always_comb begin
        d_next = DIST_W'(WIN + 1);
        d_prev = DIST_W'(WIN + 1);
        for (int k = WIN; k >= 1; k--) begin
            if (tap[WIN-k]) d_next = DIST_W'(k);
            if (tap[WIN+k]) d_prev = DIST_W'(k);
        end
    end

    // Closer follower asks for late, closer predecessor for early.
    always_comb begin
        if (!center_hit)
            dir = SHIFT_NONE;
        else if (d_next < d_prev)
            dir = SHIFT_LATE;
        else if (d_prev < d_next)
            dir = SHIFT_EARLY;
        else
            dir = SHIFT_NONE;
    end
endmodule

// File: rtl/wpc_emit.sv
`timescale 1ns/1ps
// Places each classified pulse into an output delay line at slot
// MAX_DLY +/- steps and shifts it out. Assumes pulses never collide.
module wpc_emit
    import wpc_pkg::*;
#(
    parameter int MAX_DLY = 6,
    parameter int STEP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              center_hit,
    input  shift_dir_t        dir,
    input  logic [STEP_W-1:0] shift_steps,
    output logic              wd_out
);
    localparam int LINE = 2 * MAX_DLY + 1;

    logic [LINE-1:0] out_line;
    logic [LINE-1:0] ins;
    int              slot;

    // Choose the insertion slot and build a one-hot mask for it.
    always_comb begin
        case (dir)
            SHIFT_LATE:  slot = MAX_DLY + int'(shift_steps);
            SHIFT_EARLY: slot = MAX_DLY - int'(shift_steps);
            default:     slot = MAX_DLY;
        endcase
        for (int i = 0; i < LINE; i++)
            ins[i] = center_hit && (i == slot);
    end

    // Advance the line by one slot per clock and merge the new pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_line <= '0;
        else
            out_line <= {1'b0, out_line[LINE-1:1]} | ins;
    end

    assign wd_out = out_line[0];
endmodule

// File: rtl/write_precomp.sv
`timescale 1ns/1ps
// Write precompensation top: pattern classifier, shift decoder and
// output delay line. Latency is WIN+1+MAX_DLY clocks for an unshifted pulse.
// Assumes input pulse spacing of at least 2*MAX_DLY+2 clocks.
module write_precomp
    import wpc_pkg::*;
#(
    parameter int TRACK_W      = 8,
    parameter int WIN          = 16,
    parameter int CLK_PER_UNIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wd_in,
    input  logic [2:0]         pc_code,
    input  logic [1:0]         rate_sel,
    input  logic [TRACK_W-1:0] track_cur,
    input  logic [TRACK_W-1:0] track_start,
    output logic               wd_out
);
    localparam int MAX_DLY = UNITS_MAX * CLK_PER_UNIT;
    localparam int STEP_W  = $clog2(MAX_DLY + 1);

    logic              center_hit;
    shift_dir_t        dir;
    logic [STEP_W-1:0] shift_steps;

    wpc_pattern #(.WIN(WIN)) u_pattern (
        .clk(clk), .rst_n(rst_n), .wd_in(wd_in),
        .center_hit(center_hit), .dir(dir)
    );

    wpc_step_decode #(.TRACK_W(TRACK_W), .CLK_PER_UNIT(CLK_PER_UNIT), .STEP_W(STEP_W)) u_decode (
        .pc_code(pc_code), .rate_sel(rate_sel),
        .track_cur(track_cur), .track_start(track_start),
        .shift_steps(shift_steps)
    );

    wpc_emit #(.MAX_DLY(MAX_DLY), .STEP_W(STEP_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .center_hit(center_hit), .dir(dir),
        .shift_steps(shift_steps), .wd_out(wd_out)
    );
endmodule

// File: rtl/wpc_chk.sv
`timescale 1ns/1ps
// Assertion checker bound to write_precomp.
module wpc_chk #(
    parameter int TRACK_W = 8,
    parameter int STEP_W  = 3,
    parameter int MAX_DLY = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         pc_code,
    input logic [TRACK_W-1:0] track_cur,
    input logic [TRACK_W-1:0] track_start,
    input logic [STEP_W-1:0]  shift_steps,
    input logic               wd_out
);
    logic was_rst;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        // R1
        if (was_rst === 1'b1)
            r1_idle_chk: assert (wd_out == 1'b0) else $error("output active right after reset");
    end

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_out |=> !wd_out);

    // R5
    code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_code == 3'b111) |-> (shift_steps == '0));

    // R8
    track_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track_cur < track_start) |-> (shift_steps == '0));

    // R6
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(shift_steps) <= MAX_DLY);
endmodule

bind write_precomp wpc_chk #(.TRACK_W(TRACK_W), .STEP_W(STEP_W), .MAX_DLY(MAX_DLY)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_code(pc_code), .track_cur(track_cur),
    .track_start(track_start), .shift_steps(shift_steps), .wd_out(wd_out)
);

// File: tb/write_precomp_test.sv
`timescale 1ns/1ps
module write_precomp_test;
    localparam int W    = 16;
    localparam int MAXD = 6;
    localparam int N    = 14000;
    localparam int MAXP = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_in = 1'b0;
    logic [2:0] pc_code = 3'b0;
    logic [1:0] rate_sel = 2'b0;
    logic [7:0] track_cur = 8'd0;
    logic [7:0] track_start = 8'd0;
    logic       wd_out;

    write_precomp uut (
        .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .pc_code(pc_code),
        .rate_sel(rate_sel), .track_cur(track_cur), .track_start(track_start),
        .wd_out(wd_out)
    );

    always #2 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    in_bit [0:N+64];
    bit    exp_bit [0:N+64];
    string exp_tag [0:N+64];
    int    c_code [0:N+64];
    int    c_rate [0:N+64];
    int    c_trk [0:N+64];
    int    c_st [0:N+64];
    int    pt [0:MAXP-1];
    string ptag [0:MAXP-1];
    int    np = 0;
    int    pos = 1;
    int    g [0:15];
    int    seen = 0;

    // Shift size from the requirements (R5, R6, R7, R8).
    function automatic int want_steps(int code, int rate, int trk, int st);
        if (trk < st) return 0;
        if (code == 7) return 0;
        if (code == 0) return (rate == 3) ? 1 : 3;
        return code;
    endfunction

    // Append one burst: settings held from burst start to the idle gap end.
    task automatic add_seg(int code, int rate, int trk, int st, int n, string tag);
        int t;
        int s0;
        s0 = pos;
        t = pos + 5;
        for (int i = 0; i < n; i++) begin
            if (i > 0) t = t + g[i-1];
            in_bit[t] = 1'b1;
            pt[np] = t;
            ptag[np] = tag;
            np++;
        end
        pos = t + 60;
        for (int c = s0; c < pos; c++) begin
            c_code[c] = code; c_rate[c] = rate; c_trk[c] = trk; c_st[c] = st;
        end
    endtask

    task automatic set_pattern();
        g[0] = 14; g[1] = 20; g[2] = 20; g[3] = 14; g[4] = 30;
    endtask

    task automatic check(bit act, bit exp, string tag, int c);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d wd_out actual=%0b expected=%0b", tag, c, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int prv, nxt, s, p, idx;
        void'($urandom(32'd5150));
        for (int c = 0; c <= N + 64; c++) begin
            in_bit[c] = 0; exp_bit[c] = 0; exp_tag[c] = "R9";
            c_code[c] = 7; c_rate[c] = 2; c_trk[c] = 0; c_st[c] = 0;
        end
        // Directed bursts.
        g[0] = 0;
        add_seg(2, 2, 5, 0, 1, "R2");                    // isolated pulse R2
        set_pattern(); add_seg(7, 2, 10, 0, 6, "R5");    // off code R5
        for (int code = 1; code <= 6; code++) begin
            set_pattern(); add_seg(code, 1, 3, 0, 6, "R6"); // each step size R6
        end
        for (int r = 0; r < 4; r++) begin
            set_pattern(); add_seg(0, r, 7, 0, 6, "R7");    // rate default R7
        end
        set_pattern(); add_seg(5, 0, 9, 10, 6, "R8");    // below start R8
        set_pattern(); add_seg(5, 0, 10, 10, 6, "R8");   // at start R8
        // Random bursts; directions tagged R2/R3/R4 below.
        for (int k = 0; k < 25; k++) begin
            for (int i = 0; i < 12; i++) g[i] = 14 + int'($urandom_range(0, 10));
            add_seg(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 30)), int'($urandom_range(0, 20)),
                    6 + int'($urandom_range(0, 6)), "");
        end
        // Expected output table.
        for (int j = 0; j < np; j++) begin
            prv = (j > 0 && pt[j] - pt[j-1] <= W) ? pt[j] - pt[j-1] : W + 1;
            nxt = (j < np - 1 && pt[j+1] - pt[j] <= W) ? pt[j+1] - pt[j] : W + 1;
            s = want_steps(c_code[pt[j]], c_rate[pt[j]], c_trk[pt[j]], c_st[pt[j]]);
            p = MAXD;
            if (nxt < prv) p = MAXD + s;
            else if (prv < nxt) p = MAXD - s;
            idx = pt[j] + W + 1 + p;
            exp_bit[idx] = 1'b1;
            if (ptag[j] != "") exp_tag[idx] = ptag[j];
            else if (nxt < prv) exp_tag[idx] = "R3";
            else if (prv < nxt) exp_tag[idx] = "R4";
            else exp_tag[idx] = "R2";
        end

        // Reset phase with pulses on the input (R1).
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            wd_in = (c % 3 == 0);
            check(wd_out, 1'b0, "R1", -1);
        end
        @(negedge clk);
        wd_in = 1'b0;
        rst_n = 1'b1;

        for (int c = 1; c < pos + 40 && c <= N; c++) begin
            wd_in = in_bit[c];
            pc_code = 3'(c_code[c]);
            rate_sel = 2'(c_rate[c]);
            track_cur = 8'(c_trk[c]);
            track_start = 8'(c_st[c]);
            @(posedge clk);
            @(negedge clk);
            if (c == 1) check(wd_out, 1'b0, "R1", c);
            else check(wd_out, exp_bit[c], exp_tag[c], c);
            if (wd_out) seen++;
        end
        // R9: output pulse count equals input pulse count.
        total++;
        if (seen != np) begin
            bad++;
            $display("FAIL R9 pulse count actual=%0d expected=%0d", seen, np);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule